// File: doc/BRIEF.md
# UART receive queue with line status and interrupt control

This block is the receive-side status and interrupt core of a 16550-style UART channel. A receive shifter hands it characters, each with its own parity, framing and break flags. The block queues them in a 16-entry FIFO, with the error tags of each character stored next to its data. Around the queue it keeps the interrupt-enable register and builds the line-status byte and the interrupt identification code. It also drives the interrupt pin.

The host pops characters with a receive-data read. A line-status read acknowledges the errors. An identification read retires a transmit-ready event that has been reported. The transmitter reports its holding-register and shifter state, and the modem block reports a pending modem-status change. The host chooses FIFO or single-register operation and one of four receive trigger levels. When all four enables are clear, the host polls the status bits and the pin stays quiet.

Top module: `rxq_top`

## Requirements
- R1: After reset, the enable register reads 0x00, `iir_o` is 4'b0001, `irq_o` is 0, and line-status bits 0 to 4 and bit 7 are 0.
- R2: Characters leave in arrival order. `rhr_data_o` shows the oldest character, and `rhr_re_i` removes it when the queue is not empty.
- R3: Line-status bit 0 is 1 from the cycle after a character is accepted until the queue becomes empty.
- R4: A character is dropped if it arrives while the queue holds its capacity (16 with `fifo_en_i`=1, 1 otherwise) and no pop happens in the same cycle. Line-status bit 1 is then 1 from the next cycle. A line-status read clears it, unless another drop happens in that same cycle.
- R5: Line-status bits 4, 3 and 2 show the break, framing and parity tags of the oldest character. After a line-status read they read 0 until that character is popped.
- R6: Line-status bit 7 is 1 while any queued character carries any error tag. Reads do not change it.
- R7: Line-status bit 5 equals `thr_empty_i`. Bit 6 equals `thr_empty_i` AND `tsr_empty_i`.
- R8: `ier_we_i` loads bits 3:0 of the enable register from `ier_wdata_i`. Bits 7:4 of `ier_o` read 0.
- R9: With enable bit 0 set and `fifo_en_i`=1, receive-data-available is pending while the count is at least the trigger level. `trig_sel_i` values 0, 1, 2 and 3 select 1, 4, 8 and 14. With `fifo_en_i`=0, it is pending while the queue holds a character.
- R10: A transmit-ready event is armed when `thr_empty_i` rises, or when a write sets enable bit 1 from 0 while `thr_empty_i` is 1. It is pending while armed and enable bit 1 is set. It is disarmed when `thr_empty_i` is 0, or when `iir_re_i` is asserted while it is the reported source.
- R11: `iir_o` reports the highest-priority pending source. The codes are: line status 4'b0110 (enable bit 2 and any of line-status bits 1 to 4), receive data 4'b0100, transmit ready 4'b0010, modem status 4'b0000 (enable bit 3 and `msr_change_i`), and none 4'b0001.
- R12: `irq_o` is 1 exactly when `iir_o[0]` is 0. With enable bits 3:0 all 0, it stays 0 while the status bits keep updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error tag |
| rx_ferr_i | input | 1 | Framing error tag |
| rx_brk_i | input | 1 | Break tag |
| rhr_re_i | input | 1 | Host read of receive data (pop) |
| lsr_re_i | input | 1 | Host read of line status |
| iir_re_i | input | 1 | Host read of interrupt identification |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 4 | Enable register write data, bits 3:0 |
| thr_empty_i | input | 1 | Transmit holding register or FIFO empty |
| tsr_empty_i | input | 1 | Transmit shifter empty |
| msr_change_i | input | 1 | Modem status change pending |
| fifo_en_i | input | 1 | FIFO mode select |
| trig_sel_i | input | 2 | Receive trigger level select |
| rhr_data_o | output | 8 | Oldest queued character |
| ier_o | output | 8 | Enable register readback |
| lsr_o | output | 8 | Line status |
| iir_o | output | 4 | Interrupt identification code |
| irq_o | output | 1 | Interrupt pin, active high |

## Verification
The bench aims at these corner cases, each with the wrong behaviour it would catch:
- A push and a pop in the same cycle on a full queue. A design that gets this wrong loses data or flags a false overrun.
- The count crossing the trigger level in both directions. A sticky or off-by-one receive interrupt shows up here.
- An error tag that is acknowledged while another erroneous character waits behind it. A design that clears the summary bit 7 or keeps showing the acknowledged tags fails this case.
- Transmit-ready arming by an enable write while the holding register is already empty, and its disarming by an identification read only when it is the reported source. A design that misses the first never interrupts. A design that gets the second wrong loses transmit-ready behind a higher-priority source.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [3:0] {
    IIR_MSR  = 4'b0000,
    IIR_NONE = 4'b0001,
    IIR_THRE = 4'b0010,
    IIR_RDA  = 4'b0100,
    IIR_RLS  = 4'b0110
  } iir_code_e;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  rx_char_t      wr_char_i,
  input  logic          fifo_en_i,
  output rx_char_t      head_o,
  output logic [CW-1:0] cnt_o,
  output logic          pop_ok_o,
  output logic          push_ok_o,
  output logic          drop_o,
  output logic          err_any_o
);
  rx_char_t      mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
  logic [CW-1:0] cnt_q, err_cnt_q, cap;
  logic          full, wr_err, hd_err;

  assign cap       = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign full      = cnt_q >= cap;
  assign pop_ok_o  = pop_i && (cnt_q != '0);
  assign push_ok_o = push_i && (!full || pop_ok_o);
  assign drop_o    = push_i && !push_ok_o;
  assign head_o    = mem_q[rd_ptr_q];
  assign cnt_o     = cnt_q;
  assign err_any_o = err_cnt_q != '0;
  assign wr_err    = wr_char_i.brk | wr_char_i.ferr | wr_char_i.perr;
  assign hd_err    = head_o.brk | head_o.ferr | head_o.perr;

  // pointer wrap: free for power-of-two depths, compare otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr_q + 1'b1;
      assign rd_nxt = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_nxt = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= wr_char_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      err_cnt_q <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= wr_nxt;
      if (pop_ok_o)  rd_ptr_q <= rd_nxt;
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      case ({push_ok_o && wr_err, pop_ok_o && hd_err})
        2'b10:   err_cnt_q <= err_cnt_q + 1'b1;
        2'b01:   err_cnt_q <= err_cnt_q - 1'b1;
        default: err_cnt_q <= err_cnt_q;
      endcase
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok_o && !pop_ok_o) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !pop_i) |=> (cnt_o == $past(cnt_o))); // R4
endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_nz_i,
  input  logic [2:0] hd_tags_i,
  input  logic       drop_i,
  input  logic       pop_ok_i,
  input  logic       lsr_re_i,
  input  logic       err_any_i,
  input  logic       thr_empty_i,
  input  logic       tsr_empty_i,
  output logic [7:0] lsr_o,
  output logic       line_err_o
);
  logic       ovr_q, ack_q;
  logic [2:0] tags;

  assign tags       = (cnt_nz_i && !ack_q) ? hd_tags_i : 3'b000;
  assign lsr_o      = {err_any_i, thr_empty_i & tsr_empty_i, thr_empty_i,
                       tags, ovr_q, cnt_nz_i};
  assign line_err_o = ovr_q | (|tags);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      if (drop_i)        ovr_q <= 1'b1;
      else if (lsr_re_i) ovr_q <= 1'b0;
      // acknowledgement of head tags lasts until the head changes
      if (pop_ok_i || !cnt_nz_i) ack_q <= 1'b0;
      else if (lsr_re_i)         ack_q <= 1'b1;
    end
  end

  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> lsr_o[1]); // R4
  AST_DR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lsr_o[0]) |-> $past(pop_ok_i)); // R3
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
#(
  parameter int unsigned CW = 5,
  parameter int unsigned TRIG_LVL [4] = '{1, 4, 8, 14}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ier_we_i,
  input  logic [3:0]    ier_wdata_i,
  input  logic          iir_re_i,
  input  logic          thr_empty_i,
  input  logic          line_err_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          fifo_en_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          msr_change_i,
  output logic [7:0]    ier_o,
  output logic [3:0]    iir_o,
  output logic          irq_o
);
  logic [3:0]    ier_q;
  logic          thr_q, thre_q, arm;
  logic          rls_p, rda_p, thre_p, ms_p;
  logic [CW-1:0] trig;
  iir_code_e     code;

  assign trig   = CW'(TRIG_LVL[trig_sel_i]);
  assign rls_p  = ier_q[2] & line_err_i;
  assign rda_p  = ier_q[0] & (fifo_en_i ? (cnt_i >= trig) : (cnt_i != '0));
  assign thre_p = ier_q[1] & thre_q;
  assign ms_p   = ier_q[3] & msr_change_i;
  assign arm    = thr_empty_i & (!thr_q | (ier_we_i & ier_wdata_i[1] & !ier_q[1]));

  always_comb begin
    if (rls_p)       code = IIR_RLS;
    else if (rda_p)  code = IIR_RDA;
    else if (thre_p) code = IIR_THRE;
    else if (ms_p)   code = IIR_MSR;
    else             code = IIR_NONE;
  end

  assign iir_o = code;
  assign irq_o = (code != IIR_NONE);
  assign ier_o = {4'b0000, ier_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q  <= '0;
      thr_q  <= 1'b1;
      thre_q <= 1'b0;
    end else begin
      thr_q <= thr_empty_i;
      if (ier_we_i) ier_q <= ier_wdata_i;
      if (!thr_empty_i)                          thre_q <= 1'b0;
      else if (arm)                              thre_q <= 1'b1;
      else if (iir_re_i && (code == IIR_THRE))   thre_q <= 1'b0;
    end
  end

  AST_POLLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[3:0] == 4'b0000) |-> !irq_o); // R12
  AST_THRE_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_we_i && ier_wdata_i[1] && !ier_o[1] && thr_empty_i) |=> thre_q); // R10
  AST_RDA_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((iir_o == IIR_RDA) && fifo_en_i) |-> (cnt_i >= trig)); // R9
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_perr_i,
  input  logic       rx_ferr_i,
  input  logic       rx_brk_i,
  input  logic       rhr_re_i,
  input  logic       lsr_re_i,
  input  logic       iir_re_i,
  input  logic       ier_we_i,
  input  logic [3:0] ier_wdata_i,
  input  logic       thr_empty_i,
  input  logic       tsr_empty_i,
  input  logic       msr_change_i,
  input  logic       fifo_en_i,
  input  logic [1:0] trig_sel_i,
  output logic [7:0] rhr_data_o,
  output logic [7:0] ier_o,
  output logic [7:0] lsr_o,
  output logic [3:0] iir_o,
  output logic       irq_o
);
  rx_char_t      wr_char, head;
  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok, drop, err_any, line_err;

  assign wr_char    = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i, data: rx_data_i};
  assign rhr_data_o = head.data;

  rxq_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .pop_i(rhr_re_i), .wr_char_i(wr_char),
    .fifo_en_i, .head_o(head), .cnt_o(cnt), .pop_ok_o(pop_ok),
    .push_ok_o(push_ok), .drop_o(drop), .err_any_o(err_any)
  );

  rxq_lsr i_lsr (
    .clk_i, .rst_ni,
    .cnt_nz_i(cnt != '0), .hd_tags_i({head.brk, head.ferr, head.perr}),
    .drop_i(drop), .pop_ok_i(pop_ok), .lsr_re_i, .err_any_i(err_any),
    .thr_empty_i, .tsr_empty_i, .lsr_o, .line_err_o(line_err)
  );

  rxq_irq #(.CW(CW)) i_irq (
    .clk_i, .rst_ni, .ier_we_i, .ier_wdata_i, .iir_re_i, .thr_empty_i,
    .line_err_i(line_err), .cnt_i(cnt), .fifo_en_i, .trig_sel_i,
    .msr_change_i, .ier_o, .iir_o, .irq_o
  );

  AST_ACCEPT_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok && !pop_ok) |=> lsr_o[0]); // R3
endmodule

// File: tb/test_rxq_top.sv
module test_rxq_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       rx_valid_i = 0, rx_perr_i = 0, rx_ferr_i = 0, rx_brk_i = 0;
  logic [7:0] rx_data_i = 0;
  logic       rhr_re_i = 0, lsr_re_i = 0, iir_re_i = 0, ier_we_i = 0;
  logic [3:0] ier_wdata_i = 0;
  logic       thr_empty_i = 1, tsr_empty_i = 1, msr_change_i = 0, fifo_en_i = 1;
  logic [1:0] trig_sel_i = 0;
  logic [7:0] rhr_data_o, ier_o, lsr_o;
  logic [3:0] iir_o;
  logic       irq_o;

  int n_chk = 0, n_bad = 0, n_cyc = 0;

  always #2 clk = ~clk;

  rxq_top i_rxq_top (
    .clk_i(clk), .rst_ni, .rx_valid_i, .rx_data_i, .rx_perr_i, .rx_ferr_i,
    .rx_brk_i, .rhr_re_i, .lsr_re_i, .iir_re_i, .ier_we_i, .ier_wdata_i,
    .thr_empty_i, .tsr_empty_i, .msr_change_i, .fifo_en_i, .trig_sel_i,
    .rhr_data_o, .ier_o, .lsr_o, .iir_o, .irq_o
  );

  // reference model state
  logic [10:0] mq[$];
  bit          m_ovr, m_ack, m_thrq, m_thre;
  logic [3:0]  m_ier;

  function automatic logic [2:0] m_tags();
    return (mq.size() > 0 && !m_ack) ? mq[0][10:8] : 3'b000;
  endfunction

  function automatic logic [7:0] exp_lsr();
    bit e7 = 0;
    foreach (mq[i]) if (mq[i][10:8] != 0) e7 = 1;
    return {e7, thr_empty_i & tsr_empty_i, thr_empty_i, m_tags(), m_ovr, mq.size() > 0};
  endfunction

  function automatic logic [3:0] exp_iir();
    int tl;
    bit rda;
    case (trig_sel_i) 2'd0: tl = 1; 2'd1: tl = 4; 2'd2: tl = 8; default: tl = 14; endcase
    rda = fifo_en_i ? (mq.size() >= tl) : (mq.size() > 0);
    if (m_ier[2] && (m_ovr || m_tags() != 0)) return 4'b0110;
    if (m_ier[0] && rda)                       return 4'b0100;
    if (m_ier[1] && m_thre)                    return 4'b0010;
    if (m_ier[3] && msr_change_i)              return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic model_step();
    int         cap = fifo_en_i ? DEPTH : 1;
    bit         pop = rhr_re_i && mq.size() > 0;
    bit         full = mq.size() >= cap;
    bit         pok = rx_valid_i && (!full || pop);
    bit         drop = rx_valid_i && !pok;
    logic [3:0] cur = exp_iir();
    bit         setev = thr_empty_i && (!m_thrq || (ier_we_i && ier_wdata_i[1] && !m_ier[1]));
    if (pop || mq.size() == 0) m_ack = 0; else if (lsr_re_i) m_ack = 1;
    if (drop) m_ovr = 1; else if (lsr_re_i) m_ovr = 0;
    if (!thr_empty_i) m_thre = 0;
    else if (setev) m_thre = 1;
    else if (iir_re_i && cur == 4'b0010) m_thre = 0;
    m_thrq = thr_empty_i;
    if (ier_we_i) m_ier = ier_wdata_i;
    if (pop) void'(mq.pop_front());
    if (pok) mq.push_back({rx_brk_i, rx_ferr_i, rx_perr_i, rx_data_i});
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mq.delete(); m_ovr = 0; m_ack = 0; m_thrq = 1; m_thre = 0; m_ier = 0;
    end else model_step();
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [7:0] el = exp_lsr();
    logic [3:0] ei = exp_iir();
    if (mq.size() > 0) chk("R2", "rhr_data", rhr_data_o, mq[0][7:0]);
    chk("R3", "lsr0", lsr_o[0], el[0]);
    chk("R4", "lsr1", lsr_o[1], el[1]);
    chk("R5", "lsr4_2", lsr_o[4:2], el[4:2]);
    chk("R7", "lsr6_5", lsr_o[6:5], el[6:5]);
    chk("R6", "lsr7", lsr_o[7], el[7]);
    chk("R8", "ier", ier_o, {4'b0, m_ier});
    chk("R11", "iir", iir_o, ei);
    chk("R12", "irq", irq_o, ei != 4'b0001);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", n_cyc);
      summary();
    end
  end

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    rx_valid_i = 0; rhr_re_i = 0; lsr_re_i = 0; iir_re_i = 0; ier_we_i = 0;
    rx_perr_i = 0; rx_ferr_i = 0; rx_brk_i = 0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] tags);
    rx_valid_i = 1; rx_data_i = d; {rx_brk_i, rx_ferr_i, rx_perr_i} = tags;
    cycle();
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin rhr_re_i = 1; cycle(); end
  endtask

  task automatic wr_ier(input logic [3:0] v);
    ier_we_i = 1; ier_wdata_i = v; cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ier", ier_o, 8'h00);
    chk("R1", "iir", iir_o, 4'b0001);
    chk("R1", "irq", irq_o, 1'b0);
    chk("R1", "lsr", lsr_o & 8'h9f, 8'h00);
    // R8 reserved bits
    ier_we_i = 1; ier_wdata_i = 4'hf; cycle();
    chk("R8", "ier", ier_o, 8'h0f);
    wr_ier(4'h0);
    // R12 polled mode, R3 data ready
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i), 3'b000);
    chk("R12", "irq polled", irq_o, 1'b0);
    chk("R3", "lsr0", lsr_o[0], 1'b1);
    // R9 trigger level 4, both directions
    trig_sel_i = 2'd1; wr_ier(4'h1);
    chk("R9", "iir at 5", iir_o, 4'b0100);
    pop_n(2);
    chk("R9", "iir at 3", iir_o, 4'b0001);
    chk("R2", "head order", rhr_data_o, 8'h12);
    push(8'h20, 3'b000);
    chk("R9", "iir at 4", iir_o, 4'b0100);
    pop_n(4);
    chk("R3", "lsr0 empty", lsr_o[0], 1'b0);
    // R4 overrun in FIFO mode
    wr_ier(4'h4);
    for (int i = 0; i < 17; i++) push(8'(i), 3'b000);
    chk("R4", "lsr1", lsr_o[1], 1'b1);
    chk("R11", "iir rls", iir_o, 4'b0110);
    chk("R2", "head after drop", rhr_data_o, 8'h00);
    lsr_re_i = 1; cycle();
    chk("R4", "lsr1 cleared", lsr_o[1], 1'b0);
    rx_valid_i = 1; rx_data_i = 8'h77; rhr_re_i = 1; cycle();
    chk("R4", "no drop on pop+push", lsr_o[1], 1'b0);
    pop_n(16);
    // R5 / R6 error tags
    push(8'h31, 3'b010);
    push(8'h32, 3'b000);
    chk("R5", "ferr tag", lsr_o[4:2], 3'b010);
    chk("R6", "lsr7 set", lsr_o[7], 1'b1);
    lsr_re_i = 1; cycle();
    chk("R5", "tags acked", lsr_o[4:2], 3'b000);
    chk("R6", "lsr7 kept", lsr_o[7], 1'b1);
    pop_n(1);
    chk("R6", "lsr7 clear", lsr_o[7], 1'b0);
    pop_n(1);
    // R10 transmit ready
    wr_ier(4'h2);
    chk("R10", "arm on enable", iir_o, 4'b0010);
    iir_re_i = 1; cycle();
    chk("R10", "iir read clears", iir_o, 4'b0001);
    thr_empty_i = 0; cycle();
    chk("R7", "lsr5", lsr_o[5], 1'b0);
    thr_empty_i = 1; cycle();
    chk("R10", "rise arms", iir_o, 4'b0010);
    // R11 priority
    msr_change_i = 1; wr_ier(4'hf);
    chk("R11", "thre over msr", iir_o, 4'b0010);
    trig_sel_i = 2'd0; push(8'h41, 3'b001);
    chk("R11", "rls first", iir_o, 4'b0110);
    iir_re_i = 1; cycle();
    lsr_re_i = 1; cycle();
    chk("R11", "rda next", iir_o, 4'b0100);
    pop_n(1);
    chk("R11", "thre kept", iir_o, 4'b0010);
    msr_change_i = 0;
    // R9 / R4 holding-register mode
    fifo_en_i = 0; wr_ier(4'h1);
    push(8'h51, 3'b000);
    chk("R9", "rda non-fifo", iir_o, 4'b0100);
    push(8'h52, 3'b000);
    chk("R4", "single overrun", lsr_o[1], 1'b1);
    chk("R2", "kept first", rhr_data_o, 8'h51);
    pop_n(1);
    fifo_en_i = 1;
    // randomized phase compared against the model every cycle
    for (int c = 0; c < 6000; c++) begin
      rx_valid_i = ($urandom_range(0, 9) < 4);
      rx_data_i = 8'($urandom);
      rx_perr_i = ($urandom_range(0, 9) == 0);
      rx_ferr_i = ($urandom_range(0, 9) == 0);
      rx_brk_i = ($urandom_range(0, 19) == 0);
      rhr_re_i = ($urandom_range(0, 9) < 3);
      lsr_re_i = ($urandom_range(0, 9) == 0);
      iir_re_i = ($urandom_range(0, 9) == 0);
      ier_we_i = ($urandom_range(0, 19) == 0);
      ier_wdata_i = 4'($urandom);
      if ($urandom_range(0, 9) == 0) thr_empty_i = ~thr_empty_i;
      if ($urandom_range(0, 9) == 0) tsr_empty_i = ~tsr_empty_i;
      if ($urandom_range(0, 19) == 0) msr_change_i = ~msr_change_i;
      if ($urandom_range(0, 199) == 0) fifo_en_i = ~fifo_en_i;
      if ($urandom_range(0, 99) == 0) trig_sel_i = 2'($urandom);
      cycle();
    end
    summary();
  end
endmodule